// File: doc/BRIEF.md
# Supervisor/User Mode Trap Controller

This block holds the privilege state of a processor core: either supervisor mode, where every instruction class may run, or restricted user mode, where a fixed set of classes is forbidden. Each cycle it takes the class of the decoded instruction and decides one of two things. Either the instruction may proceed, and the block raises the matching write enable or I/O enable, or the instruction must not run, and the block requests a trap. The block also owns a free-running interval timer and a bank of external interrupt request lines. It folds all of these trap sources into one registered trap request with a cause code. Taking any trap puts the core into supervisor mode.

There are two interrupt groups. High-priority lines can interrupt in either mode. Low-priority lines are held off while the core is in supervisor mode, but each request is latched so it can be served later. Timer expiries that fall in supervisor mode are held the same way. A return operation, legal only in supervisor mode, drops the core to user mode. In the first user cycle after the return, the held requests become eligible again. The trap handler, the instruction decoder and the vector fetch sit outside this block.

Top module: `mode_trap_ctrl`

## Requirements
- R1: After reset, `sup_mode` is 1, `trap_valid` is 0, `trap_cause` is 0 and every enable output is 0.
- R2: When `sup_mode` is 1 and `instr_valid` is 1, the same cycle raises exactly one enable for the class: class 1 gives `io_en`, class 2 gives `area_we`, class 3 gives `mask_we` and class 4 gives `prot_we`. In user mode, no enable is ever raised.
- R3: In user mode, a valid instruction of class 1, 2, 3, 4 or 5 (return) raises no enable. In the next cycle, `trap_valid` is 1, `trap_cause` is 1 (privileged) and `sup_mode` is 1.
- R4: A valid class-5 return in supervisor mode, with no trap taken in that cycle, makes `sup_mode` 0 in the next cycle.
- R5: The timer fires every PERIOD cycles. A firing in user mode gives `trap_valid` with `trap_cause` 2 in the next cycle. With the core kept in user mode, consecutive timer traps are exactly PERIOD cycles apart.
- R6: A timer firing in supervisor mode causes no trap and is held. It is delivered as a cause-2 trap in the cycle after the first user-mode cycle that follows a return.
- R7: A request on a low-priority line (index NUM_HIGH or above) in supervisor mode causes no trap and is held. It is delivered as a cause-3 trap with `trap_irq_id` set to that line, in the cycle after the first user-mode cycle.
- R8: A request on a high-priority line (index below NUM_HIGH) gives a cause-3 trap with that line's id in the next cycle, in either mode.
- R9: When causes coincide, privileged beats timer and timer beats external. A request that loses stays held and is delivered later. Every trap leaves `sup_mode` at 1.
- R10: Among eligible interrupt lines, the lowest index wins. `trap_valid` is a one-cycle pulse per trap. While it is 0, `trap_cause` and `trap_irq_id` are 0.
- R11: In user mode, a valid class-0 instruction raises no enable and no trap, and the mode stays user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented this cycle |
| instr_class | input | 3 | 0 normal, 1 I/O, 2 memory-area switch, 3 mask load, 4 protection load, 5 return |
| irq_req | input | NUM_IRQ | External interrupt request pulses, one per line |
| sup_mode | output | 1 | 1 = supervisor mode, 0 = user mode |
| trap_valid | output | 1 | One-cycle trap request |
| trap_cause | output | 3 | 0 none, 1 privileged, 2 timer, 3 external |
| trap_irq_id | output | clog2(NUM_IRQ) | Interrupt line that caused an external trap |
| io_en | output | 1 | I/O instruction may execute |
| area_we | output | 1 | Memory-area selection may be written |
| mask_we | output | 1 | Interrupt mask register may be written |
| prot_we | output | 1 | Protection registers may be written |

## Verification
The bench builds the block with PERIOD = 64, NUM_IRQ = 4 and NUM_HIGH = 1. This timer period is short enough that several expiries happen within one run. Each scenario first waits for a timer trap, which gives it a known phase. It can then place a low-priority request in exactly the same cycle as a timer firing, or let a firing fall in supervisor mode. With one high line and three low lines, the bench can test simultaneous requests across both groups and within the low group. That covers lock-out, latching, the lowest-index-wins rule and the release of held requests after a return.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   typedef enum logic [2:0] {
      CLS_NORMAL = 3'd0,
      CLS_IO     = 3'd1,
      CLS_AREA   = 3'd2,
      CLS_MASK   = 3'd3,
      CLS_PROT   = 3'd4,
      CLS_RETURN = 3'd5
   } instr_cls_e;

   typedef enum logic [2:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_PRIV  = 3'd1,
      CAUSE_TIMER = 3'd2,
      CAUSE_EXT   = 3'd3
   } trap_cause_e;

endpackage

// File: rtl/mtc_timer.sv
module mtc_timer #(
   parameter int unsigned PERIOD = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("mtc_timer: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R5: every firing restarts the interval from zero
   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));

endmodule

// File: rtl/mtc_irq_arb.sv
module mtc_irq_arb #(
   parameter int unsigned NUM_IRQ  = 8,
   parameter int unsigned NUM_HIGH = 2,
   localparam int unsigned IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               user_mode,
   input  logic               block,
   output logic               hit,
   output logic [IDW-1:0]     hit_id
);
   generate
      if (NUM_HIGH > NUM_IRQ) begin : g_bad_split
         $error("mtc_irq_arb: NUM_HIGH exceeds NUM_IRQ");
      end
   endgenerate

   logic [NUM_IRQ-1:0] pend, live, elig, grant;

   assign live = pend | irq_req;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (i < NUM_HIGH) begin : g_high
         assign elig[i] = live[i];
      end else begin : g_low
         assign elig[i] = live[i] & user_mode;
      end
   end

   always_comb begin
      grant  = '0;
      hit_id = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (elig[i]) begin
            grant  = '0;
            grant[i] = 1'b1;
            hit_id = IDW'(i);
         end
      end
      if (block) begin
         grant  = '0;
         hit_id = '0;
      end
   end

   assign hit = |grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= live & ~grant;
   end

   // R10: at most one line is served per cycle
   assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7: a held request is dropped only by being served
   assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && (live != '0)) |=> (pend == $past(live)));

endmodule

// File: rtl/mtc_perm_gate.sv
module mtc_perm_gate
   import mtc_pkg::*;
(
   input  logic       sup_mode,
   input  logic       instr_valid,
   input  logic [2:0] instr_class,
   output logic       io_en,
   output logic       area_we,
   output logic       mask_we,
   output logic       prot_we,
   output logic       ret_ok,
   output logic       priv_fault
);
   instr_cls_e cls;
   logic       is_priv;

   always_comb begin
      cls     = instr_cls_e'(instr_class);
      is_priv = 1'b0;
      case (cls)
         CLS_IO, CLS_AREA, CLS_MASK, CLS_PROT, CLS_RETURN: is_priv = 1'b1;
         default:                                          is_priv = 1'b0;
      endcase
   end

   assign io_en      = sup_mode & instr_valid & (cls == CLS_IO);
   assign area_we    = sup_mode & instr_valid & (cls == CLS_AREA);
   assign mask_we    = sup_mode & instr_valid & (cls == CLS_MASK);
   assign prot_we    = sup_mode & instr_valid & (cls == CLS_PROT);
   assign ret_ok     = sup_mode & instr_valid & (cls == CLS_RETURN);
   assign priv_fault = ~sup_mode & instr_valid & is_priv;

   // R2: the class decode grants at most one right at a time
   always_comb begin
      assert_one_enable_R2: assert ($onehot0({io_en, area_we, mask_we, prot_we, ret_ok}));
   end

endmodule

// File: rtl/mode_trap_ctrl.sv
module mode_trap_ctrl
   import mtc_pkg::*;
#(
   parameter int unsigned PERIOD   = 5_000_000,
   parameter int unsigned NUM_IRQ  = 8,
   parameter int unsigned NUM_HIGH = 2,
   localparam int unsigned IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [2:0]         instr_class,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic               sup_mode,
   output logic               trap_valid,
   output logic [2:0]         trap_cause,
   output logic [IDW-1:0]     trap_irq_id,
   output logic               io_en,
   output logic               area_we,
   output logic               mask_we,
   output logic               prot_we
);
   logic           tick, tmr_pend, tmr_elig;
   logic           ret_ok, priv_fault;
   logic           take_tmr, irq_hit, any_trap;
   logic [IDW-1:0] irq_id;

   mtc_timer #(.PERIOD(PERIOD)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   mtc_perm_gate u_gate (
      .sup_mode    (sup_mode),
      .instr_valid (instr_valid),
      .instr_class (instr_class),
      .io_en       (io_en),
      .area_we     (area_we),
      .mask_we     (mask_we),
      .prot_we     (prot_we),
      .ret_ok      (ret_ok),
      .priv_fault  (priv_fault)
   );

   assign tmr_elig = ~sup_mode & (tick | tmr_pend);
   assign take_tmr = tmr_elig & ~priv_fault;

   mtc_irq_arb #(.NUM_IRQ(NUM_IRQ), .NUM_HIGH(NUM_HIGH)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .user_mode (~sup_mode),
      .block     (priv_fault | tmr_elig),
      .hit       (irq_hit),
      .hit_id    (irq_id)
   );

   assign any_trap = priv_fault | take_tmr | irq_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_mode    <= 1'b1;
         tmr_pend    <= 1'b0;
         trap_valid  <= 1'b0;
         trap_cause  <= CAUSE_NONE;
         trap_irq_id <= '0;
      end else begin
         tmr_pend    <= (tmr_pend | tick) & ~take_tmr;
         trap_valid  <= any_trap;
         trap_irq_id <= irq_hit ? irq_id : '0;
         if (priv_fault)    trap_cause <= CAUSE_PRIV;
         else if (take_tmr) trap_cause <= CAUSE_TIMER;
         else if (irq_hit)  trap_cause <= CAUSE_EXT;
         else               trap_cause <= CAUSE_NONE;
         if (any_trap)      sup_mode <= 1'b1;
         else if (ret_ok)   sup_mode <= 1'b0;
      end
   end

   // R2: user mode never grants a protected write
   assert_user_no_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_mode |-> !(io_en | area_we | mask_we | prot_we));

   // R3: a forbidden class in user mode traps with the privileged cause
   assert_priv_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sup_mode && instr_valid && (instr_class inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}))
      |=> (trap_valid && trap_cause == CAUSE_PRIV && sup_mode));

   // R4: leaving supervisor mode needs a return in the previous cycle
   assert_leave_by_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sup_mode) |-> $past(instr_valid && instr_class == CLS_RETURN));

   // R9: every trap lands in supervisor mode
   assert_trap_in_sup_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> sup_mode);

   // R10: cause and id are zero between traps
   assert_idle_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |-> (trap_cause == CAUSE_NONE && trap_irq_id == '0));

endmodule

// File: tb/mode_trap_ctrl_tb_top.sv
module mode_trap_ctrl_tb_top;
   localparam int unsigned PER   = 64;
   localparam int unsigned NIRQ  = 4;
   localparam int unsigned NHIGH = 1;
   localparam int unsigned IDW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [2:0]      instr_class = 3'd0;
   logic [NIRQ-1:0] irq_req = '0;
   logic            sup_mode, trap_valid;
   logic [2:0]      trap_cause;
   logic [IDW-1:0]  trap_irq_id;
   logic            io_en, area_we, mask_we, prot_we;

   int tests_run = 0;
   int tests_bad = 0;
   bit finished  = 0;

   always #2 clk = ~clk;

   mode_trap_ctrl #(.PERIOD(PER), .NUM_IRQ(NIRQ), .NUM_HIGH(NHIGH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_class (instr_class),
      .irq_req     (irq_req),
      .sup_mode    (sup_mode),
      .trap_valid  (trap_valid),
      .trap_cause  (trap_cause),
      .trap_irq_id (trap_irq_id),
      .io_en       (io_en),
      .area_we     (area_we),
      .mask_we     (mask_we),
      .prot_we     (prot_we)
   );

   function automatic logic [3:0] ens();
      return {prot_we, mask_we, area_we, io_en};
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      tests_run++;
      if (act != exp) begin
         tests_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drv(logic v, logic [2:0] c, logic [NIRQ-1:0] irq);
      instr_valid = v;
      instr_class = c;
      irq_req     = irq;
   endtask

   task automatic idle();
      drv(1'b0, 3'd0, '0);
   endtask

   // Wait for a timer trap; returns at that negedge in supervisor mode.
   task automatic sync_timer();
      bit seen = 0;
      idle();
      for (int n = 0; n < 4 * PER && !seen; n++) begin
         @(negedge clk);
         if (trap_valid && trap_cause == 3'd2) seen = 1;
         else drv(sup_mode, sup_mode ? 3'd5 : 3'd0, '0);
      end
      idle();
      chk("R5", "timer trap found", int'(seen), 1);
   endtask

   task automatic go_user(string req);
      drv(1'b1, 3'd5, '0);
      @(negedge clk);
      idle();
      chk(req, "user after return", int'(sup_mode), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "sup_mode", int'(sup_mode), 1);
      chk("R1", "trap_valid", int'(trap_valid), 0);
      chk("R1", "trap_cause", int'(trap_cause), 0);
      chk("R1", "enables", int'(ens()), 0);
   endtask

   task automatic t_sup_enables();
      sync_timer();
      for (int c = 1; c <= 4; c++) begin
         drv(1'b1, 3'(c), '0);
         #1;
         chk("R2", "enable for class", int'(ens()), 1 << (c - 1));
      end
      drv(1'b1, 3'd0, '0);
      #1;
      chk("R2", "normal class in sup", int'(ens()), 0);
      idle();
   endtask

   task automatic t_user_priv();
      sync_timer();
      go_user("R4");
      drv(1'b1, 3'd0, '0);
      #1;
      chk("R11", "no enable normal", int'(ens()), 0);
      @(negedge clk);
      idle();
      chk("R11", "no trap normal", int'(trap_valid), 0);
      chk("R11", "still user", int'(sup_mode), 0);
      for (int c = 1; c <= 5; c++) begin
         drv(1'b1, 3'(c), '0);
         #1;
         chk("R3", "no enable in user", int'(ens()), 0);
         @(negedge clk);
         idle();
         chk("R3", "priv trap", int'(trap_valid), 1);
         chk("R3", "priv cause", int'(trap_cause), 1);
         chk("R3", "enters sup", int'(sup_mode), 1);
         @(negedge clk);
         chk("R10", "pulse ends", int'(trap_valid), 0);
         chk("R10", "cause cleared", int'(trap_cause), 0);
         if (c < 5) go_user("R4");
      end
   endtask

   task automatic t_timer();
      sync_timer();
      go_user("R4");
      for (int n = 1; n < PER - 1; n++) begin
         @(negedge clk);
         if (trap_valid) chk("R5", "early trap", 1, 0);
      end
      drv(1'b0, 3'd0, 4'b0100);
      @(negedge clk);
      idle();
      chk("R5", "timer trap at period", int'(trap_valid), 1);
      chk("R9", "timer beats ext", int'(trap_cause), 2);
      chk("R9", "sup after timer", int'(sup_mode), 1);
      go_user("R9");
      @(negedge clk);
      chk("R9", "held ext served", int'(trap_cause), 3);
      chk("R9", "held ext id", int'(trap_irq_id), 2);
   endtask

   task automatic t_timer_pend();
      int hits = 0;
      sync_timer();
      for (int n = 0; n < PER + 2; n++) begin
         @(negedge clk);
         if (trap_valid) hits++;
      end
      chk("R6", "no trap in sup", hits, 0);
      go_user("R6");
      @(negedge clk);
      chk("R6", "held timer trap", int'(trap_valid), 1);
      chk("R6", "held timer cause", int'(trap_cause), 2);
   endtask

   task automatic t_low_irq();
      int hits = 0;
      sync_timer();
      drv(1'b0, 3'd0, 4'b0100);
      @(negedge clk);
      idle();
      for (int n = 0; n < 3; n++) begin
         if (trap_valid) hits++;
         @(negedge clk);
      end
      chk("R7", "low locked in sup", hits, 0);
      go_user("R7");
      chk("R7", "no trap first user cycle", int'(trap_valid), 0);
      @(negedge clk);
      chk("R7", "low delivered", int'(trap_cause), 3);
      chk("R7", "low id", int'(trap_irq_id), 2);
      chk("R7", "sup after low", int'(sup_mode), 1);
   endtask

   task automatic t_high_irq();
      sync_timer();
      drv(1'b0, 3'd0, 4'b0101);
      @(negedge clk);
      idle();
      chk("R8", "high traps in sup", int'(trap_cause), 3);
      chk("R8", "high id", int'(trap_irq_id), 0);
      @(negedge clk);
      go_user("R8");
      @(negedge clk);
      chk("R7", "low held behind high", int'(trap_irq_id), 2);
      chk("R7", "low cause", int'(trap_cause), 3);
      go_user("R8");
      drv(1'b0, 3'd0, 4'b0001);
      @(negedge clk);
      idle();
      chk("R8", "high traps in user", int'(trap_cause), 3);
      chk("R8", "high id user", int'(trap_irq_id), 0);
   endtask

   task automatic t_precedence();
      sync_timer();
      go_user("R4");
      drv(1'b1, 3'd3, 4'b1010);
      @(negedge clk);
      idle();
      chk("R9", "priv wins", int'(trap_cause), 1);
      go_user("R9");
      @(negedge clk);
      chk("R10", "lowest line first", int'(trap_irq_id), 1);
      chk("R10", "ext cause", int'(trap_cause), 3);
      go_user("R9");
      @(negedge clk);
      chk("R10", "next line", int'(trap_irq_id), 3);
      chk("R9", "loser kept", int'(trap_valid), 1);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         tests_run++;
         tests_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sup_enables();
      t_user_priv();
      t_timer();
      t_timer_pend();
      t_low_irq();
      t_high_irq();
      t_precedence();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
      $finish;
   end

endmodule